// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used page translations and turns a 32-bit virtual address into a physical address. Pages are 8 KB. Each lookup carries an address-space tag and an access kind (read, write or instruction fetch). The buffer has 48 slots and searches all of them at once. The result is registered: it appears one clock after the request and shows a hit with the physical address, a miss, or a protection fault. On every matching access, hardware sets the slot's reference flag. A write that completes also sets the slot's dirty flag.

A miss handler outside this block walks the page tables and then writes the translation through the fill port. The block picks the slot to replace and shows that choice on an output before the fill is issued. It fills a free slot first. When every slot is valid, it uses a rotating pointer that skips the slot used most recently. A flush input drops every translation in one cycle when the address space changes.

Top module: `tlb_xlate`

## Requirements
- R1: The buffer has 48 slots, and any translation may sit in any slot. A slot matches a lookup when it is valid and both its stored page number and its space tag equal the lookup's `lk_vaddr[31:13]` and `lk_asid`. `rs_slot` reports the number of the matching slot. If several slots match, the lowest-numbered one is used, and an assertion flags this case as an error.
- R2: A lookup presented at one clock edge has its result on the `rs_*` outputs after that edge and until the next one. On a hit, `rs_paddr` = {stored frame, `lk_vaddr[12:0]`}. `rs_paddr` is zero unless `rs_hit` is high. Every `rs_*` output is zero in a cycle that follows no lookup.
- R3: After reset every slot is invalid, so every lookup misses. A lookup that matches no slot raises `rs_miss` and keeps `rs_hit` and `rs_fault` low. A translation stored under a different space tag does not match.
- R4: `lk_mode` is coded 00 read, 01 write, 10 fetch, and 11 is treated as read. A write that matches a slot whose write-enable flag is clear raises `rs_fault`. In that case `rs_hit` stays low and `rs_paddr` is zero. Reads and fetches never fault.
- R5: Every lookup that matches a slot sets that slot's reference flag, whether it hits or faults. `rs_ref` shows the flag as it stood before the access.
- R6: A write that completes through a slot sets that slot's dirty flag. A faulted write leaves the flag unchanged. `rs_dirty` shows the flag as it stood before the access.
- R7: A fill writes the page number, space tag, frame, valid flag and write-enable flag into the slot shown on `fl_slot`, and clears that slot's reference and dirty flags. `fl_slot` shows the lowest-numbered invalid slot whenever one exists.
- R8: When every slot is valid, `fl_slot` shows the rotating pointer, or the slot after it (wrapping from 47 to 0) when the pointer equals the last-used slot. The last-used slot is the most recent slot matched by a lookup or written by a fill; a fill counts over a lookup in the same cycle. A fill into a full buffer moves the pointer to the slot after the victim. Reset sets both the pointer and the last-used slot to 0.
- R9: `flush` clears every valid flag in one cycle. A fill in the same cycle is still installed.
- R10: A lookup in the same cycle as a fill or a flush sees the contents from before that edge. If the fill overwrites the slot the lookup matched, the fill's cleared flags win over the lookup's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space tag of the lookup |
| lk_mode | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| fl_req | input | 1 | Install a translation |
| fl_vpn | input | 19 | Virtual page number to install |
| fl_asid | input | 8 | Space tag to install |
| fl_pfn | input | 19 | Physical frame number to install |
| fl_valid | input | 1 | Valid flag to install |
| fl_wr_ok | input | 1 | Write-enable flag to install |
| fl_slot | output | 6 | Slot the next fill will write |
| rs_valid | output | 1 | A lookup result is present |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No matching slot |
| rs_fault | output | 1 | Write refused by protection |
| rs_paddr | output | 32 | Translated physical address |
| rs_slot | output | 6 | Slot that matched |
| rs_ref | output | 1 | Reference flag before this access |
| rs_dirty | output | 1 | Dirty flag before this access |

## Verification
The two functions that can fall in the same cycle are a lookup and a fill, sometimes joined by a flush. The bench provokes this in two ways. In a directed case, a lookup targets exactly the slot that `fl_slot` names while the fill is issued, and flush-plus-fill cycles follow. In a long pseudo-random phase, lookups, fills and rare flushes overlap freely. A behavioural model updates its slot contents in a fixed order: first the lookup's flag updates, then the flush, then the fill. It compares every result output and `fl_slot` on each clock. The outcome is judged by three things: the overlapping lookup reports the old translation, a later lookup of the old page misses, and the new page hits with clean flags.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    parameter int VA_W   = 32;
    parameter int OFF_W  = 13;
    parameter int VPN_W  = VA_W - OFF_W;
    parameter int PFN_W  = 19;
    parameter int PA_W   = PFN_W + OFF_W;
    parameter int ASID_W = 8;
    parameter int N_ENT  = 48;
    localparam int IDX_W = $clog2(N_ENT);

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic              wr_ok;
        logic              refd;
        logic              dirty;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } tlb_ent_t;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            fault;
        logic            refd;
        logic            dirty;
        idx_t            slot;
        logic [PA_W-1:0] paddr;
    } res_t;

    function automatic idx_t lowest_set(input logic [N_ENT-1:0] v);
        idx_t r;
        r = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i);
        end
        return r;
    endfunction

    function automatic idx_t wrap_inc(input idx_t i);
        return (i == idx_t'(N_ENT - 1)) ? '0 : i + idx_t'(1);
    endfunction
endpackage

// File: rtl/tlb_entries.sv
`timescale 1ns/1ps
module tlb_entries import tlb_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              fill_we,
    input  idx_t              fill_idx,
    input  tlb_ent_t          fill_ent,
    input  logic              touch_en,
    input  idx_t              touch_idx,
    input  logic              touch_dirty,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASID_W-1:0] look_asid,
    output logic [N_ENT-1:0]  match_vec,
    output logic [N_ENT-1:0]  valid_vec,
    output tlb_ent_t          sel_ent,
    output idx_t              sel_idx
);
    tlb_ent_t ent [N_ENT];

    // Order inside one edge: flag updates, then flush, then fill (fill wins).
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                if (flush) ent[i].valid <= 1'b0;
                if (touch_en && touch_idx == idx_t'(i)) begin
                    ent[i].refd <= 1'b1;
                    if (touch_dirty) ent[i].dirty <= 1'b1;
                end
                if (fill_we && fill_idx == idx_t'(i)) ent[i] <= fill_ent;
            end
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign valid_vec[g] = ent[g].valid;
        assign match_vec[g] = ent[g].valid
                              && (ent[g].vpn == look_vpn)
                              && (ent[g].asid == look_asid);
    end

    assign sel_idx = lowest_set(match_vec);
    assign sel_ent = ent[sel_idx];

    // R1: two slots holding the same translation is an error
    p_single_match_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    // R9: a flush without a fill leaves nothing valid
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (flush && !fill_we) |=> (valid_vec == '0));

    // R9: a valid fill alongside a flush survives alone
    p_flush_keeps_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (flush && fill_we && fill_ent.valid) |=> ($countones(valid_vec) == 1));
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim import tlb_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] valid_vec,
    input  logic             fill_we,
    input  logic             use_en,
    input  idx_t             use_idx,
    output idx_t             victim
);
    idx_t rr_q;
    idx_t last_q;
    logic full;

    assign full = &valid_vec;

    always_comb begin
        if (!full)               victim = lowest_set(~valid_vec);
        else if (rr_q == last_q) victim = wrap_inc(rr_q);
        else                     victim = rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q   <= '0;
            last_q <= '0;
        end else if (fill_we) begin
            last_q <= victim;
            if (full) rr_q <= wrap_inc(victim);
        end else if (use_en) begin
            last_q <= use_idx;
        end
    end

    // R8: the slot just matched is never the next replacement choice
    p_spare_last_r8: assert property (@(posedge clk) disable iff (rst)
        (use_en && !fill_we) |=> (!full || victim != $past(use_idx)));
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate import tlb_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_mode,
    input  logic              fl_req,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic              fl_valid,
    input  logic              fl_wr_ok,
    output logic [IDX_W-1:0]  fl_slot,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_miss,
    output logic              rs_fault,
    output logic [PA_W-1:0]   rs_paddr,
    output logic [IDX_W-1:0]  rs_slot,
    output logic              rs_ref,
    output logic              rs_dirty
);
    logic [N_ENT-1:0] match_vec;
    logic [N_ENT-1:0] valid_vec;
    tlb_ent_t         sel_ent;
    tlb_ent_t         fill_ent;
    idx_t             sel_idx;
    idx_t             victim;
    logic             any_m;
    logic             is_wr;
    logic             deny;
    logic             touch_en;
    logic             touch_dirty;
    res_t             nxt;
    res_t             res_q;

    assign any_m       = |match_vec;
    assign is_wr       = (lk_mode == ACC_WRITE);
    assign deny        = is_wr && !sel_ent.wr_ok;
    assign touch_en    = lk_req && any_m;
    assign touch_dirty = is_wr && sel_ent.wr_ok;

    always_comb begin
        fill_ent       = '0;
        fill_ent.valid = fl_valid;
        fill_ent.wr_ok = fl_wr_ok;
        fill_ent.asid  = fl_asid;
        fill_ent.vpn   = fl_vpn;
        fill_ent.pfn   = fl_pfn;
    end

    tlb_entries u_ent (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .fill_we     (fl_req),
        .fill_idx    (victim),
        .fill_ent    (fill_ent),
        .touch_en    (touch_en),
        .touch_idx   (sel_idx),
        .touch_dirty (touch_dirty),
        .look_vpn    (lk_vaddr[VA_W-1:OFF_W]),
        .look_asid   (lk_asid),
        .match_vec   (match_vec),
        .valid_vec   (valid_vec),
        .sel_ent     (sel_ent),
        .sel_idx     (sel_idx)
    );

    tlb_victim u_vic (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .fill_we   (fl_req),
        .use_en    (touch_en),
        .use_idx   (sel_idx),
        .victim    (victim)
    );

    always_comb begin
        nxt = '0;
        if (lk_req) begin
            nxt.valid = 1'b1;
            if (!any_m) begin
                nxt.miss = 1'b1;
            end else begin
                nxt.slot  = sel_idx;
                nxt.refd  = sel_ent.refd;
                nxt.dirty = sel_ent.dirty;
                if (deny) begin
                    nxt.fault = 1'b1;
                end else begin
                    nxt.hit   = 1'b1;
                    nxt.paddr = {sel_ent.pfn, lk_vaddr[OFF_W-1:0]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign fl_slot  = victim;
    assign rs_valid = res_q.valid;
    assign rs_hit   = res_q.hit;
    assign rs_miss  = res_q.miss;
    assign rs_fault = res_q.fault;
    assign rs_paddr = res_q.paddr;
    assign rs_slot  = res_q.slot;
    assign rs_ref   = res_q.refd;
    assign rs_dirty = res_q.dirty;

    // R2: an allowed match returns the page offset unchanged one cycle later
    p_hit_offset_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_req && any_m && !deny) |=>
            (rs_hit && rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R2: no request, no result
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> (!rs_valid && !rs_hit && !rs_miss && !rs_fault));

    // R3: no matching slot gives a miss only
    p_miss_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !any_m) |=> (rs_miss && !rs_hit && !rs_fault));

    // R4: refused write faults and yields no address
    p_deny_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_req && any_m && deny) |=> (rs_fault && !rs_hit && rs_paddr == '0));
endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
    import tlb_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              flush = 1'b0;
    logic              lk_req = 1'b0;
    logic [VA_W-1:0]   lk_vaddr = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [1:0]        lk_mode = '0;
    logic              fl_req = 1'b0;
    logic [VPN_W-1:0]  fl_vpn = '0;
    logic [ASID_W-1:0] fl_asid = '0;
    logic [PFN_W-1:0]  fl_pfn = '0;
    logic              fl_valid = 1'b0;
    logic              fl_wr_ok = 1'b0;
    logic [IDX_W-1:0]  fl_slot;
    logic              rs_valid, rs_hit, rs_miss, rs_fault, rs_ref, rs_dirty;
    logic [PA_W-1:0]   rs_paddr;
    logic [IDX_W-1:0]  rs_slot;

    tlb_xlate u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_mode(lk_mode),
        .fl_req(fl_req), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_pfn(fl_pfn),
        .fl_valid(fl_valid), .fl_wr_ok(fl_wr_ok), .fl_slot(fl_slot),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
        .rs_paddr(rs_paddr), .rs_slot(rs_slot), .rs_ref(rs_ref), .rs_dirty(rs_dirty)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R3 reset";
    bit    armed = 1'b0;

    // behavioural reference state
    int m_vpn [N_ENT];
    int m_asid[N_ENT];
    int m_pfn [N_ENT];
    bit m_v[N_ENT], m_w[N_ENT], m_r[N_ENT], m_d[N_ENT];
    int m_rr, m_last;
    bit e_valid, e_hit, e_miss, e_fault, e_ref, e_dirty;
    logic [PA_W-1:0] e_paddr;
    int e_slot;

    function automatic bit m_full();
        for (int i = 0; i < N_ENT; i++) if (!m_v[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_victim();
        int c;
        for (int i = 0; i < N_ENT; i++) if (!m_v[i]) return i;
        c = m_rr;
        if (c == m_last) c = (c + 1) % N_ENT;
        return c;
    endfunction

    function automatic bit m_has(input int vpn, input int asid);
        for (int i = 0; i < N_ENT; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int m_slot_of(input int vpn, input int asid);
        for (int i = 0; i < N_ENT; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        int  v, hi;
        bit  full;
        armed = 1'b1;
        {e_valid, e_hit, e_miss, e_fault, e_ref, e_dirty} = '0;
        e_paddr = '0;
        e_slot  = 0;
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) begin
                m_v[i] = 0; m_w[i] = 0; m_r[i] = 0; m_d[i] = 0;
                m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0;
            end
            m_rr = 0;
            m_last = 0;
        end else begin
            v    = m_victim();
            full = m_full();
            if (lk_req) begin
                e_valid = 1'b1;
                hi = m_slot_of(int'(lk_vaddr[VA_W-1:OFF_W]), int'(lk_asid));
                if (hi < 0) begin
                    e_miss = 1'b1;
                end else begin
                    e_slot  = hi;
                    e_ref   = m_r[hi];
                    e_dirty = m_d[hi];
                    m_r[hi] = 1'b1;
                    m_last  = hi;
                    if (lk_mode == 2'b01 && !m_w[hi]) begin
                        e_fault = 1'b1;
                    end else begin
                        e_hit   = 1'b1;
                        e_paddr = {PFN_W'(m_pfn[hi]), lk_vaddr[OFF_W-1:0]};
                        if (lk_mode == 2'b01) m_d[hi] = 1'b1;
                    end
                end
            end
            if (flush) for (int i = 0; i < N_ENT; i++) m_v[i] = 1'b0;
            if (fl_req) begin
                m_v[v] = fl_valid; m_w[v] = fl_wr_ok; m_r[v] = 0; m_d[v] = 0;
                m_vpn[v] = int'(fl_vpn); m_asid[v] = int'(fl_asid); m_pfn[v] = int'(fl_pfn);
                m_last = v;
                if (full) m_rr = (v + 1) % N_ENT;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s (%s) actual=%0h expected=%0h t=%0t", tag, cur_tag, act, exp, $time);
        end
    endtask

    // compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            chk({rs_valid, rs_hit, rs_miss, rs_fault} == {e_valid, e_hit, e_miss, e_fault},
                e_miss ? "R3" : (e_fault ? "R4" : "R2"),
                {rs_valid, rs_hit, rs_miss, rs_fault}, {e_valid, e_hit, e_miss, e_fault});
            chk(rs_paddr == e_paddr, "R2", rs_paddr, e_paddr);
            chk(int'(rs_slot) == e_slot, "R1", rs_slot, e_slot);
            chk(rs_ref == e_ref, "R5", rs_ref, e_ref);
            chk(rs_dirty == e_dirty, "R6", rs_dirty, e_dirty);
            chk(int'(fl_slot) == m_victim(), m_full() ? "R8" : "R7", fl_slot, m_victim());
        end
    end

    task automatic drive(input bit rq, input logic [1:0] md, input logic [VA_W-1:0] va,
                         input logic [ASID_W-1:0] as, input bit f, input logic [VPN_W-1:0] fv,
                         input logic [ASID_W-1:0] fa, input logic [PFN_W-1:0] fp,
                         input bit fvld, input bit fw, input bit fls);
        lk_req = rq; lk_mode = md; lk_vaddr = va; lk_asid = as;
        fl_req = f; fl_vpn = fv; fl_asid = fa; fl_pfn = fp; fl_valid = fvld; fl_wr_ok = fw;
        flush = fls;
    endtask

    task automatic step(input bit rq, input logic [1:0] md, input logic [VA_W-1:0] va,
                        input logic [ASID_W-1:0] as, input bit f, input logic [VPN_W-1:0] fv,
                        input logic [ASID_W-1:0] fa, input logic [PFN_W-1:0] fp,
                        input bit fvld, input bit fw, input bit fls);
        @(posedge clk); #1;
        drive(rq, md, va, as, f, fv, fa, fp, fvld, fw, fls);
    endtask

    task automatic look(input logic [1:0] md, input logic [VPN_W-1:0] vpn,
                        input logic [OFF_W-1:0] off, input logic [ASID_W-1:0] as);
        step(1, md, {vpn, off}, as, 0, '0, '0, '0, 0, 0, 0);
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] as,
                        input logic [PFN_W-1:0] pfn, input bit w);
        step(0, 2'b00, '0, '0, 1, vpn, as, pfn, 1, w, 0);
    endtask

    task automatic idle();
        step(0, 2'b00, '0, '0, 0, '0, '0, '0, 0, 0, 0);
    endtask

    function automatic logic [VPN_W-1:0] vpn_of(input int i);
        return VPN_W'(32'h100 + i * 3);
    endfunction

    function automatic logic [PFN_W-1:0] pfn_of(input int i);
        return PFN_W'(32'h2000 + i * 11);
    endfunction

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r, r2;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        cur_tag = "R3 empty lookups";
        look(2'b00, vpn_of(0), 13'h10, 8'd1);
        look(2'b10, vpn_of(5), 13'h0, 8'd1);

        cur_tag = "R7 fill all slots";
        for (int i = 0; i < N_ENT; i++) fill(vpn_of(i), 8'd1, pfn_of(i), (i % 3) != 0);

        cur_tag = "R1 R2 lookup every slot";
        for (int i = N_ENT - 1; i >= 0; i--) look(2'b00, vpn_of(i), OFF_W'(i * 97 + 5), 8'd1);

        cur_tag = "R5 second access shows reference";
        look(2'b10, vpn_of(7), 13'h1fff, 8'd1);
        look(2'b11, vpn_of(7), 13'h0001, 8'd1);

        cur_tag = "R4 write to protected slot";
        look(2'b01, vpn_of(3), 13'h0abc, 8'd1);
        look(2'b01, vpn_of(3), 13'h0abc, 8'd1);
        look(2'b10, vpn_of(3), 13'h0004, 8'd1);

        cur_tag = "R6 dirty after completed write";
        look(2'b01, vpn_of(4), 13'h0100, 8'd1);
        look(2'b01, vpn_of(4), 13'h0104, 8'd1);
        look(2'b00, vpn_of(4), 13'h0108, 8'd1);

        cur_tag = "R3 other space tag misses";
        look(2'b00, vpn_of(4), 13'h0, 8'd2);
        look(2'b00, VPN_W'(19'h7ffff), 13'h0, 8'd1);

        cur_tag = "R8 replacement when full";
        fill(VPN_W'(19'h40000), 8'd1, PFN_W'(19'h30000), 1);
        look(2'b00, vpn_of(1), 13'h0, 8'd1);
        fill(VPN_W'(19'h40001), 8'd1, PFN_W'(19'h30001), 1);
        idle();

        cur_tag = "R10 lookup of victim during fill";
        @(posedge clk); #1;
        begin
            int s;
            s = m_victim();
            drive(1, 2'b00, {VPN_W'(m_vpn[s]), 13'h0123}, 8'(m_asid[s]),
                  1, VPN_W'(19'h40002), 8'd1, PFN_W'(19'h30002), 1, 0, 0);
        end
        @(posedge clk); #1;
        drive(0, 2'b00, '0, '0, 0, '0, '0, '0, 0, 0, 0);
        look(2'b00, VPN_W'(19'h40002), 13'h0055, 8'd1);
        look(2'b01, VPN_W'(19'h40002), 13'h0055, 8'd1);

        cur_tag = "R9 flush with lookup";
        step(1, 2'b00, {vpn_of(10), 13'h0}, 8'd1, 0, '0, '0, '0, 0, 0, 1);
        look(2'b00, vpn_of(10), 13'h0, 8'd1);
        cur_tag = "R9 flush with fill";
        step(0, 2'b00, '0, '0, 1, VPN_W'(19'h01234), 8'd5, PFN_W'(19'h04321), 1, 1, 1);
        look(2'b01, VPN_W'(19'h01234), 13'h0777, 8'd5);
        look(2'b00, vpn_of(11), 13'h0, 8'd1);
        idle();

        cur_tag = "R10 mixed random traffic";
        r = 32'h1234_5678;
        for (int n = 0; n < 2500; n++) begin
            int     fv, fa;
            bit     dofill;
            r  = xs(r);
            r2 = xs(r ^ 32'h9e37_79b9);
            fv = 32'h100 + int'(r2[5:0]) * 3;
            fa = (r2[7:6] != 2'b00) ? 1 : 2;
            @(posedge clk); #1;
            dofill = (r2[11:10] == 2'b00) && !m_has(fv, fa);
            drive(r[8] | r[9], r[11:10],
                  {VPN_W'(32'h100 + int'(r[17:12]) * 3), r[30:18]},
                  (r[20:19] != 2'b00) ? 8'd1 : 8'd2,
                  dofill, VPN_W'(fv), 8'(fa), PFN_W'(r2[31:13]),
                  r2[15:12] != 4'h0, r2[16], r2[27:22] == 6'd0);
        end
        idle();
        idle();
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule